// File: doc/BRIEF.md
# Micro Branch Target Cache

This block is a small, fully associative cache of taken-branch targets that sits in the fetch stage. A fetch address is presented with a valid strobe. In the next cycle the block reports whether that address is a known taken branch, and if so, the address to fetch next. This lets the front end redirect after a taken branch without waiting for the larger, slower predictor.

Entries are created only by branch resolution that reports a taken branch. Each entry holds the full branch address as its tag and the last target seen for that branch. A separate port from the slower main predictor lets that predictor correct the cache whenever the two disagree. It can either replace the stored target or drop the entry.

When a new branch needs a slot, a free slot is used if one exists. Otherwise a tree pseudo-LRU picks the slot to reuse. A flush input empties the whole cache in one cycle.

Top module: `ubtb_micro`

## Requirements
- R1: After reset, pred_valid and pred_hit are 0 and every lookup misses until a taken resolution is written.
- R2: pred_valid equals fetch_valid of the previous cycle. pred_hit and pred_target give, one cycle after the fetch, whether the fetch address matches a stored branch and, on a hit, its stored target.
- R3: A resolution with res_taken=1 for an absent address stores it with its target. A resolution with res_taken=0 never creates an entry.
- R4: A taken resolution for an address already stored rewrites that entry's target in place. No second entry is created, so 64 distinct branches still fit after any number of rewrites.
- R5: An override with ovr_kill=0 that matches a stored address replaces its target with ovr_target. An override that matches nothing leaves the contents unchanged and creates no entry.
- R6: An override with ovr_kill=1 that matches a stored address removes that entry, and later lookups of that address miss.
- R7: When an override and a resolution act on the same slot in the same cycle, the override's effect is the one kept.
- R8: Asserting flush for one cycle empties every entry, so every lookup issued after that edge misses.
- R9: A lookup issued in the same cycle as a write sees the contents from before that cycle's edge.
- R10: A taken resolution that allocates chooses the lowest-numbered free slot. When no slot is free, it chooses the pseudo-LRU victim, where allocations and in-place rewrites count as uses and lookups do not.
- R11: A resolution or override presented in the same cycle as flush is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty the whole cache at this edge |
| fetch_valid | input | 1 | Lookup request strobe |
| fetch_pc | input | ADDR_W | Address looked up |
| pred_valid | output | 1 | A lookup result is presented this cycle |
| pred_hit | output | 1 | Looked-up address is a stored taken branch |
| pred_target | output | ADDR_W | Predicted next fetch address (0 on miss) |
| res_valid | input | 1 | Branch resolution strobe |
| res_pc | input | ADDR_W | Resolved branch address |
| res_target | input | ADDR_W | Resolved branch target |
| res_taken | input | 1 | Branch resolved taken |
| ovr_valid | input | 1 | Main-predictor correction strobe |
| ovr_pc | input | ADDR_W | Branch address being corrected |
| ovr_kill | input | 1 | 1 removes the entry, 0 replaces its target |
| ovr_target | input | ADDR_W | Replacement target |

## Verification
Lookups are tried against addresses that were resolved taken, resolved not-taken, rewritten in place, retargeted or killed by the main predictor, and never seen. Each of these separates a correct hit or miss from a stale or spurious entry. Lookups issued in the same cycle as a write tell old-content forwarding apart from new-content forwarding. A colliding resolution and override on one branch shows which of the two wins. Filling all 64 slots and then allocating twice more shows that in-place rewrites create no duplicates, and it checks the exact victim order chosen by the pseudo-LRU tree.

// File: rtl/ubtb_pkg.sv
package ubtb_pkg;
    typedef enum logic [1:0] {
        ACT_IDLE,
        ACT_FILL,
        ACT_RETARGET,
        ACT_DROP
    } slot_act_e;
endpackage

// File: rtl/ubtb_match.sv
module ubtb_match #(
    parameter int N  = 64,
    parameter int AW = 32,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0][AW-1:0] tags,
    input  logic [N-1:0]         valid,
    input  logic [AW-1:0]        key,
    output logic [N-1:0]         hit_vec,
    output logic                 hit,
    output logic [IW-1:0]        hit_idx
);
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_cmp
            assign hit_vec[g] = valid[g] && (tags[g] == key);
        end
    endgenerate

    assign hit = |hit_vec;

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (hit_vec[i]) hit_idx = hit_idx | IW'(i);
        end
    end
endmodule

// File: rtl/ubtb_plru.sv
module ubtb_plru #(
    parameter int N = 64,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  valid,
    input  logic          touch_en,
    input  logic [IW-1:0] touch_idx,
    output logic [IW-1:0] victim_idx
);
    logic [N-2:0]  tree_q, tree_nx;
    logic [IW-1:0] tree_idx, free_idx;
    logic          free_found;

    always_comb begin
        int node;
        node = 0;
        tree_idx = '0;
        for (int l = 0; l < IW; l++) begin
            tree_idx[IW-1-l] = tree_q[node];
            node = 2 * node + 1 + int'(tree_q[node]);
        end
    end

    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                free_found = 1'b1;
                free_idx   = IW'(i);
            end
        end
    end

    assign victim_idx = free_found ? free_idx : tree_idx;

    always_comb begin
        int  node;
        logic dir;
        tree_nx = tree_q;
        node = 0;
        for (int l = 0; l < IW; l++) begin
            dir = touch_idx[IW-1-l];
            tree_nx[node] = ~dir;
            node = 2 * node + 1 + int'(dir);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        tree_q <= '0;
        else if (touch_en) tree_q <= tree_nx;
    end
endmodule

// File: rtl/ubtb_micro.sv
module ubtb_micro #(
    parameter int ENTRIES = 64,
    parameter int ADDR_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_pc,
    output logic              pred_valid,
    output logic              pred_hit,
    output logic [ADDR_W-1:0] pred_target,
    input  logic              res_valid,
    input  logic [ADDR_W-1:0] res_pc,
    input  logic [ADDR_W-1:0] res_target,
    input  logic              res_taken,
    input  logic              ovr_valid,
    input  logic [ADDR_W-1:0] ovr_pc,
    input  logic              ovr_kill,
    input  logic [ADDR_W-1:0] ovr_target
);
    import ubtb_pkg::*;
    localparam int IW = $clog2(ENTRIES);

    logic [ENTRIES-1:0]             valid_q;
    logic [ENTRIES-1:0][ADDR_W-1:0] tag_q, tgt_q;

    logic [ENTRIES-1:0] f_hit_vec, r_hit_vec, o_hit_vec;
    logic               f_hit, r_hit, o_hit;
    logic [IW-1:0]      f_idx, r_idx, o_idx, victim;

    slot_act_e     r_act, o_act;
    logic [IW-1:0] r_slot;

    ubtb_match #(.N(ENTRIES), .AW(ADDR_W)) u_fetch_cmp (
        .tags(tag_q), .valid(valid_q), .key(fetch_pc),
        .hit_vec(f_hit_vec), .hit(f_hit), .hit_idx(f_idx));

    ubtb_match #(.N(ENTRIES), .AW(ADDR_W)) u_res_cmp (
        .tags(tag_q), .valid(valid_q), .key(res_pc),
        .hit_vec(r_hit_vec), .hit(r_hit), .hit_idx(r_idx));

    ubtb_match #(.N(ENTRIES), .AW(ADDR_W)) u_ovr_cmp (
        .tags(tag_q), .valid(valid_q), .key(ovr_pc),
        .hit_vec(o_hit_vec), .hit(o_hit), .hit_idx(o_idx));

    ubtb_plru #(.N(ENTRIES)) u_plru (
        .clk(clk), .rst_n(rst_n), .valid(valid_q),
        .touch_en(r_act != ACT_IDLE), .touch_idx(r_slot),
        .victim_idx(victim));

    // Decide the action of each write port for this cycle.
    always_comb begin
        r_act  = ACT_IDLE;
        r_slot = r_hit ? r_idx : victim;
        o_act  = ACT_IDLE;
        if (res_valid && res_taken)
            r_act = r_hit ? ACT_RETARGET : ACT_FILL;
        if (ovr_valid && o_hit)
            o_act = ovr_kill ? ACT_DROP : ACT_RETARGET;
        if (o_act != ACT_IDLE && r_act != ACT_IDLE && r_slot == o_idx)
            r_act = ACT_IDLE;
        if (flush) begin
            r_act = ACT_IDLE;
            o_act = ACT_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            tag_q   <= '0;
            tgt_q   <= '0;
        end else begin
            if (flush) valid_q <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                if (r_slot == IW'(i)) begin
                    unique case (r_act)
                        ACT_FILL: begin
                            valid_q[i] <= 1'b1;
                            tag_q[i]   <= res_pc;
                            tgt_q[i]   <= res_target;
                        end
                        ACT_RETARGET: tgt_q[i] <= res_target;
                        default: ;
                    endcase
                end
                if (o_idx == IW'(i)) begin
                    unique case (o_act)
                        ACT_DROP:     valid_q[i] <= 1'b0;
                        ACT_RETARGET: tgt_q[i]   <= ovr_target;
                        default: ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pred_valid  <= 1'b0;
            pred_hit    <= 1'b0;
            pred_target <= '0;
        end else begin
            pred_valid  <= fetch_valid;
            pred_hit    <= fetch_valid && f_hit;
            pred_target <= (fetch_valid && f_hit) ? tgt_q[f_idx] : '0;
        end
    end
endmodule

// File: rtl/ubtb_micro_chk.sv
module ubtb_micro_chk #(
    parameter int N = 64
) (
    input logic         clk,
    input logic         rst_n,
    input logic         flush,
    input logic         fetch_valid,
    input logic         pred_valid,
    input logic         pred_hit,
    input logic         res_valid,
    input logic         res_taken,
    input logic [N-1:0] valid_q,
    input logic [N-1:0] f_hit_vec
);
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |=> pred_valid);
    a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |=> !pred_valid);
    a_r2_hit_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        pred_hit |-> pred_valid);
    a_r4_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(f_hit_vec));
    a_r3_no_growth_without_taken: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_valid && res_taken) |=> $countones(valid_q) <= $past($countones(valid_q)));
    a_r8_flush_then_miss: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> ##1 !pred_hit);
endmodule

bind ubtb_micro ubtb_micro_chk #(.N(ENTRIES)) u_chk (
    .clk(clk), .rst_n(rst_n), .flush(flush), .fetch_valid(fetch_valid),
    .pred_valid(pred_valid), .pred_hit(pred_hit), .res_valid(res_valid),
    .res_taken(res_taken), .valid_q(valid_q), .f_hit_vec(f_hit_vec));

// File: tb/tb_ubtb_micro.sv
module tb_ubtb_micro;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush = 1'b0;
    logic          fetch_valid = 1'b0;
    logic [AW-1:0] fetch_pc = '0;
    logic          pred_valid, pred_hit;
    logic [AW-1:0] pred_target;
    logic          res_valid = 1'b0, res_taken = 1'b0;
    logic [AW-1:0] res_pc = '0, res_target = '0;
    logic          ovr_valid = 1'b0, ovr_kill = 1'b0;
    logic [AW-1:0] ovr_pc = '0, ovr_target = '0;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    ubtb_micro #(.ENTRIES(64), .ADDR_W(AW)) dut (.*);

    // op codes: 0 resolve taken, 1 resolve not-taken, 2 lookup,
    // 3 override retarget, 4 override kill
    localparam logic [99:0] VEC [13] = '{
        {3'd0, 32'h1000, 32'h2000, 1'b0, 32'h0},
        {3'd2, 32'h1000, 32'h0,    1'b1, 32'h2000},
        {3'd1, 32'h1100, 32'h2100, 1'b0, 32'h0},
        {3'd2, 32'h1100, 32'h0,    1'b0, 32'h0},
        {3'd0, 32'h1000, 32'h2400, 1'b0, 32'h0},
        {3'd2, 32'h1000, 32'h0,    1'b1, 32'h2400},
        {3'd3, 32'h1000, 32'h2800, 1'b0, 32'h0},
        {3'd2, 32'h1000, 32'h0,    1'b1, 32'h2800},
        {3'd3, 32'h1300, 32'h3000, 1'b0, 32'h0},
        {3'd2, 32'h1300, 32'h0,    1'b0, 32'h0},
        {3'd4, 32'h1000, 32'h0,    1'b0, 32'h0},
        {3'd2, 32'h1000, 32'h0,    1'b0, 32'h0},
        {3'd2, 32'h1200, 32'h0,    1'b0, 32'h0}
    };

    task automatic check(input string req, input logic [AW:0] act, input logic [AW:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_ports();
        fetch_valid = 0; res_valid = 0; ovr_valid = 0; flush = 0;
    endtask

    task automatic do_res(input logic [AW-1:0] pc, input logic [AW-1:0] tgt, input logic tk);
        @(negedge clk);
        clear_ports();
        res_valid = 1; res_pc = pc; res_target = tgt; res_taken = tk;
        @(negedge clk);
        clear_ports();
    endtask

    task automatic do_ovr(input logic [AW-1:0] pc, input logic [AW-1:0] tgt, input logic kill);
        @(negedge clk);
        clear_ports();
        ovr_valid = 1; ovr_pc = pc; ovr_target = tgt; ovr_kill = kill;
        @(negedge clk);
        clear_ports();
    endtask

    task automatic look(input string req, input logic [AW-1:0] pc,
                        input logic eh, input logic [AW-1:0] et);
        @(negedge clk);
        fetch_valid = 1; fetch_pc = pc;
        @(negedge clk);
        clear_ports();
        check(req, {pred_hit, pred_target}, {eh, eh ? et : 32'h0});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 pred_valid", {32'h0, pred_valid}, 33'h0);
        check("R1 pred_hit", {32'h0, pred_hit}, 33'h0);
        look("R1 empty after reset", 32'h1000, 1'b0, 32'h0);

        // R2 valid timing
        @(negedge clk);
        fetch_valid = 1; fetch_pc = 32'h40;
        @(negedge clk);
        clear_ports();
        check("R2 pred_valid follows fetch", {32'h0, pred_valid}, 33'h1);
        @(negedge clk);
        check("R2 pred_valid drops", {32'h0, pred_valid}, 33'h0);

        // Table walk: R2 R3 R4 R5 R6
        foreach (VEC[k]) begin
            logic [2:0]    op;
            logic [AW-1:0] pc, tg, et;
            logic          eh;
            {op, pc, tg, eh, et} = VEC[k];
            case (op)
                3'd0: do_res(pc, tg, 1'b1);
                3'd1: do_res(pc, tg, 1'b0);
                3'd3: do_ovr(pc, tg, 1'b0);
                3'd4: do_ovr(pc, tg, 1'b1);
                default: look($sformatf("R2-R6 table row %0d", k), pc, eh, et);
            endcase
        end

        // R9 lookup in same cycle as allocation sees old contents
        @(negedge clk);
        res_valid = 1; res_pc = 32'h5000; res_target = 32'h6000; res_taken = 1;
        fetch_valid = 1; fetch_pc = 32'h5000;
        @(negedge clk);
        clear_ports();
        check("R9 same-cycle fill unseen", {pred_hit, pred_target}, 33'h0);
        look("R9 fill visible next", 32'h5000, 1'b1, 32'h6000);
        @(negedge clk);
        ovr_valid = 1; ovr_pc = 32'h5000; ovr_target = 32'h7000; ovr_kill = 0;
        fetch_valid = 1; fetch_pc = 32'h5000;
        @(negedge clk);
        clear_ports();
        check("R9 same-cycle retarget old", {pred_hit, pred_target}, {1'b1, 32'h6000});
        look("R5 retarget visible", 32'h5000, 1'b1, 32'h7000);

        // R7 override beats resolution on the same entry
        @(negedge clk);
        res_valid = 1; res_pc = 32'h5000; res_target = 32'h8000; res_taken = 1;
        ovr_valid = 1; ovr_pc = 32'h5000; ovr_kill = 1;
        @(negedge clk);
        clear_ports();
        look("R7 kill wins", 32'h5000, 1'b0, 32'h0);
        do_res(32'h5000, 32'h8000, 1'b1);
        @(negedge clk);
        res_valid = 1; res_pc = 32'h5000; res_target = 32'h8800; res_taken = 1;
        ovr_valid = 1; ovr_pc = 32'h5000; ovr_target = 32'h9900; ovr_kill = 0;
        @(negedge clk);
        clear_ports();
        look("R7 retarget wins", 32'h5000, 1'b1, 32'h9900);

        // R8 flush, R11 write during flush discarded
        do_res(32'h5100, 32'h5200, 1'b1);
        @(negedge clk);
        flush = 1;
        res_valid = 1; res_pc = 32'h9000; res_target = 32'h9100; res_taken = 1;
        @(negedge clk);
        clear_ports();
        look("R8 flushed 5000", 32'h5000, 1'b0, 32'h0);
        look("R8 flushed 5100", 32'h5100, 1'b0, 32'h0);
        look("R11 write during flush", 32'h9000, 1'b0, 32'h0);

        // R4 / R10: rewrite in place, then fill all slots
        do_res(32'h10000, 32'hA000, 1'b1);
        do_res(32'h10000, 32'hA004, 1'b1);
        for (int i = 1; i < 64; i++) do_res(32'h10000 + 4 * i, 32'hB000 + i, 1'b1);
        look("R4 rewritten entry kept", 32'h10000, 1'b1, 32'hA004);
        look("R4 last fill present", 32'h10000 + 4 * 63, 1'b1, 32'hB000 + 63);
        do_res(32'h20000, 32'hC000, 1'b1);
        look("R10 victim slot 0 replaced", 32'h10000, 1'b0, 32'h0);
        look("R10 new entry", 32'h20000, 1'b1, 32'hC000);
        look("R10 slot 1 kept", 32'h10004, 1'b1, 32'hB001);
        do_res(32'h20004, 32'hC004, 1'b1);
        look("R10 victim slot 32 replaced", 32'h10000 + 4 * 32, 1'b0, 32'h0);
        look("R10 slot 33 kept", 32'h10000 + 4 * 33, 1'b1, 32'hB000 + 33);
        look("R3 not-taken absent", 32'h1100, 1'b0, 32'h0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule